// File: doc/BRIEF.md
# One-Step Majority-Vote Corrector for Orthogonal Latin Square Codes

This block repairs the data portion of a received binary codeword. The code is an orthogonal-Latin-square code with parity-check matrix H = [M | I]. Software or a host loads H into an internal row store through a simple write port before decoding. A codeword is then presented for one cycle with a valid strobe. The block scans the stored rows one per clock. For each row it forms the parity of the row ANDed with the received word, which gives one syndrome bit per check. For every data bit it counts the failing checks that include that bit.

When the scan is complete, each count is compared with the fixed threshold floor(Q/2). A two-input multiplexer per bit then passes either the received bit or its complement to a registered output, and a one-cycle done pulse marks the result. There is no iteration and no finite-field arithmetic. Q (a prime) and T (the number of correctable errors) size everything. The design has Q*Q data bits and 2*T*Q check rows, and the codeword is the sum of the two.

Top module: `olsc_mv_corrector`

## Requirements
- R1: While rst is high and on the first cycle after it, done is 0 and dout is all zeros.
- R2: A cycle with h_we high stores h_wdata as row h_waddr of H. Bit j of a row is 1 when codeword bit j takes part in that check. Rows written later replace earlier contents, and later decodes use the new contents.
- R3: Check r fails when the XOR of (row r AND received word) is 1. Codeword bits 0..K-1 are data and bits K..N-1 are check bits, with K = Q*Q and N = K + 2*T*Q.
- R4: The vote count of data bit j is the number of failing checks whose row has bit j set. A count never exceeds the number of rows.
- R5: When the count of data bit j is greater than floor(Q/2), dout[j] is the complement of received bit j.
- R6: When the count equals or falls below floor(Q/2), dout[j] equals received bit j.
- R7: With H loaded as an orthogonal-Latin-square matrix (Q=3, T=1), any single flipped bit in a codeword (data or check) yields the original data on dout, and an error-free codeword yields its data unchanged.
- R8: done is a single-cycle pulse that rises R+2 clock edges after the edge that accepts cw_valid, where R = 2*T*Q. dout changes only in the cycle in which done is high, and otherwise holds its value.
- R9: cw_valid is ignored while a decode is in progress. The result belongs to the word accepted first, and no extra done pulse follows.
- R10: A count reaching the full row count is held without wrap. With every row of H set to all ones, an odd-weight word inverts every data bit and an even-weight word inverts none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_we | input | 1 | Write strobe for the parity-check row store |
| h_waddr | input | AW | Row index to write |
| h_wdata | input | N | Row contents, one bit per codeword position |
| cw_valid | input | 1 | Received codeword present this cycle |
| cw_data | input | N | Received codeword, data in low K bits |
| dout | output | K | Corrected data bits, registered |
| done | output | 1 | One-cycle pulse when dout is updated |

## Verification
A count that picks up a wrong row, or misses a row, shifts a bit across the threshold. That shows up as a wrong dout bit in the same done pulse that ends the affected decode, so a sweep of all error patterns exposes it within one decode. A broken control sequence shows up as a done pulse arriving at the wrong edge or repeating, or as dout moving outside a done cycle. The all-ones matrix drives every count to its maximum, so a counter that is too narrow wraps and flips the wrong bits at once.

// File: rtl/olsc_pkg.sv
package olsc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_VOTE  = 2'd3
  } dec_state_e;

  // smallest width that can represent every value 0..v
  function automatic int width_for(input int v);
    for (int w = 1; w < 32; w++) begin
      if ((1 << w) > v) return w;
    end
    return 32;
  endfunction

  function automatic int data_bits(input int q);
    return q * q;
  endfunction

  function automatic int check_rows(input int q, input int t);
    return 2 * t * q;
  endfunction

endpackage

// File: rtl/olsc_hmem.sv
module olsc_hmem #(
  parameter int ROWS  = 6,
  parameter int WIDTH = 15,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [ROWS];

  // single write port, registered read port: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/olsc_vote_acc.sv
module olsc_vote_acc #(
  parameter int K  = 9,
  parameter int N  = 15,
  parameter int CW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            acc_en,
  input  logic [N-1:0]    row,
  input  logic [N-1:0]    word,
  output logic [K*CW-1:0] cnt_flat
);

  logic syn_fail;

  // one syndrome bit: AND the row with the word, XOR-reduce
  always_comb syn_fail = ^(row & word);

  for (genvar j = 0; j < K; j++) begin : g_cnt
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        cnt_q <= '0;
      end else if (acc_en && syn_fail && row[j]) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end

    assign cnt_flat[j*CW +: CW] = cnt_q;
  end

endmodule

// File: rtl/olsc_mux_vote.sv
module olsc_mux_vote #(
  parameter int K   = 9,
  parameter int CW  = 3,
  parameter int THR = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [K-1:0]    rx_data,
  input  logic [K*CW-1:0] cnt_flat,
  output logic [K-1:0]    dout,
  output logic            done
);

  logic [K-1:0] fixed;

  for (genvar j = 0; j < K; j++) begin : g_mux
    logic flip;
    always_comb begin
      flip     = cnt_flat[j*CW +: CW] > CW'(THR);
      fixed[j] = flip ? ~rx_data[j] : rx_data[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      done <= 1'b0;
    end else begin
      done <= en;
      if (en) dout <= fixed;
    end
  end

endmodule

// File: rtl/olsc_mv_corrector.sv
module olsc_mv_corrector
  import olsc_pkg::*;
#(
  parameter int Q  = 3,
  parameter int T  = 1,
  localparam int K  = data_bits(Q),
  localparam int R  = check_rows(Q, T),
  localparam int N  = K + R,
  localparam int AW = width_for(R - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_we,
  input  logic [AW-1:0] h_waddr,
  input  logic [N-1:0]  h_wdata,
  input  logic          cw_valid,
  input  logic [N-1:0]  cw_data,
  output logic [K-1:0]  dout,
  output logic          done
);

  localparam int CW  = width_for(R);
  localparam int THR = Q / 2;

  dec_state_e      state_q;
  logic [AW-1:0]   row_q;
  logic [N-1:0]    cw_q;
  logic            acc_v_q;
  logic            acc_last_q;
  logic            idle;
  logic            accept;
  logic            rd_en;
  logic            vote_en;
  logic            scan_last;
  logic [N-1:0]    h_row;
  logic [K*CW-1:0] cnt_flat;

  always_comb begin
    idle      = (state_q == ST_IDLE);
    accept    = idle && cw_valid;
    rd_en     = (state_q == ST_SCAN);
    vote_en   = (state_q == ST_VOTE);
    scan_last = (row_q == AW'(R - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      row_q      <= '0;
      cw_q       <= '0;
      acc_v_q    <= 1'b0;
      acc_last_q <= 1'b0;
    end else begin
      acc_v_q    <= rd_en;
      acc_last_q <= rd_en && scan_last;
      case (state_q)
        ST_IDLE: begin
          if (cw_valid) begin
            cw_q    <= cw_data;
            row_q   <= '0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          row_q <= row_q + AW'(1);
          if (scan_last) state_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (acc_last_q) state_q <= ST_VOTE;
        end
        ST_VOTE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  olsc_hmem #(
    .ROWS  (R),
    .WIDTH (N),
    .AW    (AW)
  ) u_hmem (
    .clk   (clk),
    .we    (h_we),
    .waddr (h_waddr),
    .wdata (h_wdata),
    .re    (rd_en),
    .raddr (row_q),
    .rdata (h_row)
  );

  olsc_vote_acc #(
    .K  (K),
    .N  (N),
    .CW (CW)
  ) u_acc (
    .clk      (clk),
    .rst      (rst),
    .clr      (accept),
    .acc_en   (acc_v_q),
    .row      (h_row),
    .word     (cw_q),
    .cnt_flat (cnt_flat)
  );

  olsc_mux_vote #(
    .K   (K),
    .CW  (CW),
    .THR (THR)
  ) u_vote (
    .clk      (clk),
    .rst      (rst),
    .en       (vote_en),
    .rx_data  (cw_q[K-1:0]),
    .cnt_flat (cnt_flat),
    .dout     (dout),
    .done     (done)
  );

endmodule

// File: rtl/olsc_mv_chk.sv
module olsc_mv_chk
  import olsc_pkg::*;
#(
  parameter int Q = 3,
  parameter int T = 1,
  localparam int K  = data_bits(Q),
  localparam int R  = check_rows(Q, T),
  localparam int CW = width_for(R),
  localparam int LAT = R + 2,
  localparam int LW  = width_for(LAT + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            cw_valid,
  input logic            idle,
  input logic            done,
  input logic [K-1:0]    dout,
  input logic [K*CW-1:0] cnt_flat
);

  logic          active_q;
  logic [LW-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      lat_q    <= '0;
    end else if (idle && cw_valid) begin
      active_q <= 1'b1;
      lat_q    <= '0;
    end else if (active_q) begin
      if (lat_q != {LW{1'b1}}) lat_q <= lat_q + LW'(1);
      if (done) active_q <= 1'b0;
    end
  end

  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> (!done && dout == '0));

  a_r8_done_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (active_q && lat_q == LW'(LAT)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_dout_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> done);

  for (genvar j = 0; j < K; j++) begin : g_bound
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      cnt_flat[j*CW +: CW] <= CW'(R));
  end

endmodule

bind olsc_mv_corrector olsc_mv_chk #(
  .Q (Q),
  .T (T)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cw_valid (cw_valid),
  .idle     (idle),
  .done     (done),
  .dout     (dout),
  .cnt_flat (cnt_flat)
);

// File: tb/tb_olsc_mv_corrector.sv
module tb_olsc_mv_corrector;

  localparam int Q  = 3;
  localparam int T  = 1;
  localparam int K  = Q * Q;
  localparam int R  = 2 * T * Q;
  localparam int N  = K + R;
  localparam int AW = 3;
  localparam int THR = Q / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          h_we = 1'b0;
  logic [AW-1:0] h_waddr = '0;
  logic [N-1:0]  h_wdata = '0;
  logic          cw_valid = 1'b0;
  logic [N-1:0]  cw_data = '0;
  logic [K-1:0]  dout;
  logic          done;

  int n_tests = 0;
  int n_fail  = 0;
  logic [N-1:0] hb [R];
  logic [31:0]  seed = 32'h1234_5678;

  always #10 clk = ~clk;

  olsc_mv_corrector #(.Q(Q), .T(T)) dut (
    .clk(clk), .rst(rst), .h_we(h_we), .h_waddr(h_waddr), .h_wdata(h_wdata),
    .cw_valid(cw_valid), .cw_data(cw_data), .dout(dout), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // check g belongs to line family g/Q, line value g%Q
  function automatic bit ols_member(input int g, input int j);
    int s, r, a, b, ln;
    s = g / Q; r = g % Q;
    if (j >= K) return (j - K) == g;
    a = j / Q; b = j % Q;
    if (s == 0) ln = a;
    else if (s == 1) ln = b;
    else ln = (a + (s - 1) * b) % Q;
    return ln == r;
  endfunction

  function automatic logic [N-1:0] encode(input logic [K-1:0] d);
    logic [N-1:0] w;
    w = '0;
    w[K-1:0] = d;
    for (int g = 0; g < R; g++) begin
      logic p;
      p = 1'b0;
      for (int j = 0; j < K; j++) if (ols_member(g, j)) p = p ^ d[j];
      w[K+g] = p;
    end
    return w;
  endfunction

  function automatic logic [K-1:0] model(input logic [N-1:0] w);
    logic [K-1:0] res;
    for (int j = 0; j < K; j++) begin
      int c;
      c = 0;
      for (int r = 0; r < R; r++) if (hb[r][j] && (^(hb[r] & w))) c++;
      res[j] = (c > THR) ? ~w[j] : w[j];
    end
    return res;
  endfunction

  task automatic write_row(input int r, input logic [N-1:0] v);
    @(negedge clk);
    h_we = 1'b1; h_waddr = AW'(r); h_wdata = v;
    hb[r] = v;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic load_ols();
    for (int r = 0; r < R; r++) begin
      logic [N-1:0] v;
      for (int j = 0; j < N; j++) v[j] = ols_member(r, j);
      write_row(r, v);
    end
  endtask

  // decode one word, check latency, data and pulse width
  task automatic decode(input logic [N-1:0] w, input logic [K-1:0] exp,
                        input string req);
    int cyc;
    @(negedge clk);
    cw_valid = 1'b1; cw_data = w;
    @(negedge clk);
    cw_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == R + 3, "R8 latency", cyc, R + 3);
    check(dout == exp, req, dout, exp);
    @(negedge clk);
    check(!done, "R8 single pulse", done, 0);
  endtask

  initial begin
    #(200000 * 20);
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 reset done", done, 0);
    check(dout == '0, "R1 reset dout", dout, 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && dout == '0, "R1 after reset", dout, 0);

    load_ols();

    // R7 and R3: every data word, no error
    for (int d = 0; d < (1 << K); d++)
      decode(encode(K'(d)), K'(d), "R7 clean word");

    // R7/R5: every single error position over a set of data words
    for (int i = 0; i < 48; i++) begin
      logic [K-1:0] d;
      d = K'(rnd());
      for (int e = 0; e < N; e++) begin
        logic [N-1:0] w;
        w = encode(d);
        w[e] = ~w[e];
        decode(w, d, (e < K) ? "R5 data bit error" : "R7 check bit error");
      end
    end

    // R6: a check-bit error gives count exactly at threshold for its data bits
    begin
      logic [N-1:0] w;
      w = encode(K'(9'h0A5));
      w[K] = ~w[K];
      decode(w, K'(9'h0A5), "R6 count equal to threshold passes");
    end

    // R4/R5/R6: double errors against the counting model
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++) begin
        logic [N-1:0] w;
        w = encode(K'(9'h13C));
        w[a] = ~w[a]; w[b] = ~w[b];
        decode(w, model(w), "R4 double error count");
      end

    // R9: cw_valid held during a decode is ignored
    begin
      logic [N-1:0] w1;
      int extra;
      w1 = encode(K'(9'h155));
      w1[3] = ~w1[3];
      @(negedge clk);
      cw_valid = 1'b1; cw_data = w1;
      @(negedge clk);
      cw_data = encode(K'(9'h0FF));
      repeat (3) @(negedge clk);
      cw_valid = 1'b0;
      while (!done) @(negedge clk);
      check(dout == K'(9'h155), "R9 first word kept", dout, K'(9'h155));
      extra = 0;
      repeat (R + 6) begin
        @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, "R9 no extra done", extra, 0);
    end

    // R10: all-ones rows drive every count to R
    for (int r = 0; r < R; r++) write_row(r, {N{1'b1}});
    for (int i = 0; i < 64; i++) begin
      logic [N-1:0] w;
      w = N'(rnd());
      decode(w, (^w) ? ~w[K-1:0] : w[K-1:0], "R10 full count no wrap");
    end

    // R2: arbitrary matrices, then one row overwritten
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < R; r++) write_row(r, N'(rnd()));
      for (int i = 0; i < 40; i++) begin
        logic [N-1:0] w;
        w = N'(rnd());
        decode(w, model(w), "R2 loaded matrix");
      end
    end
    write_row(2, {N{1'b1}});
    for (int i = 0; i < 20; i++) begin
      logic [N-1:0] w;
      w = N'(rnd());
      decode(w, model(w), "R2 row overwrite");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule